// File: doc/BRIEF.md
# Digital Beep Tone Generator

This block produces a square-wave alert tone for an audio output path. A 48 kHz sample strobe paces it, and each strobe yields one signed 16-bit sample. One 16-bit control word holds four settings: the tone pitch, a logarithmic level, a mute bit and a choice between the generated tone and an external sample that passes straight through. Software or a sequencer writes the control word through a write-enable/data port and can read it back at any time.

The pitch field F sets the length of each half of the square wave to 2×F strobes, so the full period is 4×F strobes. F = 1 gives 12 kHz and F = 255 gives about 47 Hz. When F is zero the generator stops, its output is silent, and its phase returns to the positive half. A new F value is not applied in the middle of a half period. It takes effect when the current half ends.

The output is a stream with a valid flag and no ready. Samples arrive at the strobe rate, and the consumer must take each one in the cycle where `smp_valid` is high. The block has no back-pressure, and a sample that is not taken is lost. Between strobes, `smp_data` holds its last value.

Top module: `beep_tone_gen`

## Requirements
- R1: After reset the control word reads 0x8000, `smp_valid` is 0 and `smp_data` is 0.
- R2: A write with `cfg_we` high loads `cfg_wdata` into the control word. Bits 13 and 0 are reserved: they always read 0 and writes to them have no effect. The field positions are: bit 15 mute, bit 14 source, bits 12..5 pitch F, bits 4..1 level.
- R3: `smp_valid` is high for exactly the one cycle that follows each cycle in which `tick` is high. At all other times it is low and `smp_data` holds its value.
- R4: When the mute bit is 1, the sample is 0, whichever source is selected.
- R5: When the source bit is 1 and mute is 0, the sample equals `ext_sample` as it was in the strobe cycle.
- R6: When the source bit is 0 and F = 0, the sample is 0. The tone phase also resets, so the first sample after F becomes nonzero is positive.
- R7: When F is nonzero, the internal source gives 2×F positive samples, then 2×F negative samples, and this repeats. The first half after the tone starts is positive.
- R8: A change to F during a half period does not shorten or lengthen that half. The new F sets the length of the halves that follow.
- R9: The sample magnitude is A(level). A(0) = 32767, and A(n) = floor(A(n-1)×708/1000), which gives steps of about 3 dB. The positive half outputs +A and the negative half outputs −A, in two's complement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 48 kHz sample strobe, one cycle wide |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read-back |
| ext_sample | input | 16 | External pass-through sample, signed |
| smp_valid | output | 1 | Output sample valid, one cycle per strobe |
| smp_data | output | 16 | Output sample, signed |

## Verification
The bench changes the pitch partway through a half period and checks that the current half keeps its old length. A design that reloads at once would switch polarity too early. It switches the tone off during a negative half and back on, and checks for a positive first sample. A design that kept its phase would start negative. It writes all ones to the control word, and a design that stores the reserved bits would read them back. It also sets mute together with the external source, and a design that checks mute only on the tone path would leak the external sample.

// File: rtl/beep_pkg.sv
package beep_pkg;
  localparam int SMP_W  = 16;
  localparam int FREQ_W = 8;
  localparam int LVL_W  = 4;
  localparam int CFG_W  = 16;

  localparam int MUTE_BIT = 15;
  localparam int SRC_BIT  = 14;
  localparam int FREQ_LSB = 5;
  localparam int LVL_LSB  = 1;

  localparam logic [CFG_W-1:0] CFG_RESET = 16'h8000;
  localparam logic [CFG_W-1:0] CFG_MASK  = 16'hDFFE;

  typedef struct packed {
    logic              mute;
    logic              src_ext;
    logic [FREQ_W-1:0] freq;
    logic [LVL_W-1:0]  lvl;
  } beep_cfg_t;

  function automatic logic [SMP_W-1:0] level_of(input int n);
    int a;
    a = 32767;
    for (int i = 0; i < n; i++) a = (a * 708) / 1000;
    return a[SMP_W-1:0];
  endfunction
endpackage

// File: rtl/beep_cfg_reg.sv
module beep_cfg_reg
  import beep_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] rdata,
  output beep_cfg_t        cfg
);
  logic [CFG_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  word_q <= CFG_RESET;
    else if (we) word_q <= wdata & CFG_MASK;
  end

  assign rdata       = word_q;
  assign cfg.mute    = word_q[MUTE_BIT];
  assign cfg.src_ext = word_q[SRC_BIT];
  assign cfg.freq    = word_q[FREQ_LSB +: FREQ_W];
  assign cfg.lvl     = word_q[LVL_LSB +: LVL_W];
endmodule

// File: rtl/beep_phase_gen.sv
module beep_phase_gen #(
  parameter int FREQ_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [FREQ_W-1:0] freq,
  output logic              pos,
  output logic              active
);
  localparam int HALF_W = FREQ_W + 1;

  logic [HALF_W-1:0] cnt_q, half_q, eff, new_half;
  logic              idle_q, pos_q;

  assign new_half = {freq, 1'b0};
  assign eff      = idle_q ? new_half : half_q;
  assign active   = (freq != '0);
  assign pos      = pos_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      half_q <= '0;
      idle_q <= 1'b1;
      pos_q  <= 1'b1;
    end else if (tick) begin
      if (!active) begin
        cnt_q  <= '0;
        idle_q <= 1'b1;
        pos_q  <= 1'b1;
      end else begin
        idle_q <= 1'b0;
        if (cnt_q == eff - 1'b1) begin
          cnt_q  <= '0;
          pos_q  <= ~pos_q;
          half_q <= new_half;
        end else begin
          cnt_q  <= cnt_q + 1'b1;
          half_q <= eff;
        end
      end
    end
  end
endmodule

// File: rtl/beep_level_rom.sv
module beep_level_rom
  import beep_pkg::*;
(
  input  logic [LVL_W-1:0] lvl,
  output logic [SMP_W-1:0] amp
);
  localparam int DEPTH = 1 << LVL_W;

  logic [SMP_W-1:0] tbl [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_lvl
    assign tbl[g] = level_of(g);
  end

  assign amp = tbl[lvl];
endmodule

// File: rtl/beep_tone_gen.sv
module beep_tone_gen
  import beep_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        cfg_we,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  input  logic [15:0] ext_sample,
  output logic        smp_valid,
  output logic [15:0] smp_data
);
  beep_cfg_t        cfg;
  logic             pos, active;
  logic [SMP_W-1:0] amp, tone, nxt;

  beep_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .cfg   (cfg)
  );

  beep_phase_gen #(.FREQ_W(FREQ_W)) u_phase (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .freq   (cfg.freq),
    .pos    (pos),
    .active (active)
  );

  beep_level_rom u_rom (
    .lvl (cfg.lvl),
    .amp (amp)
  );

  always_comb begin
    if (!active)  tone = '0;
    else if (pos) tone = amp;
    else          tone = (~amp) + 1'b1;

    if (cfg.mute)         nxt = '0;
    else if (cfg.src_ext) nxt = ext_sample;
    else                  nxt = tone;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else begin
      smp_valid <= tick;
      if (tick) smp_data <= nxt;
    end
  end
endmodule

// File: rtl/beep_tone_gen_chk.sv
module beep_tone_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic [15:0] ext_sample,
  input logic [15:0] cfg_rdata,
  input logic        smp_valid,
  input logic [15:0] smp_data
);
  AST_VALID_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> smp_valid); // R3
  AST_NO_STRAY_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !smp_valid); // R3
  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |-> $stable(smp_data)); // R3
  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata[13] == 1'b0) && (cfg_rdata[0] == 1'b0)); // R2
  AST_MUTE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cfg_rdata[15] |=> smp_data == 16'h0000); // R4
  AST_EXT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !cfg_rdata[15] && cfg_rdata[14] |=> smp_data == $past(ext_sample)); // R5
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (cfg_rdata[15:14] == 2'b00) && (cfg_rdata[12:5] == 8'h00)
    |=> smp_data == 16'h0000); // R6
  AST_FULL_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
    tick && (cfg_rdata[15:14] == 2'b00) && (cfg_rdata[12:5] != 8'h00) && (cfg_rdata[4:1] == 4'h0)
    |=> (smp_data == 16'h7FFF) || (smp_data == 16'h8001)); // R9
endmodule

bind beep_tone_gen beep_tone_gen_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .ext_sample (ext_sample),
  .cfg_rdata  (cfg_rdata),
  .smp_valid  (smp_valid),
  .smp_data   (smp_data)
);

// File: tb/beep_tone_gen_tb.sv
module beep_tone_gen_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic [15:0] ext_sample = '0;
  logic        smp_valid;
  logic [15:0] smp_data;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  beep_tone_gen u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .ext_sample(ext_sample), .smp_valid(smp_valid), .smp_data(smp_data)
  );

  // {control word, external sample, expected first sample}
  localparam logic [47:0] VEC [8] = '{
    {16'h8020, 16'h0000, 16'h0000},  // R4 muted tone
    {16'h0020, 16'h0000, 16'h7FFF},  // R9 level 0
    {16'h0022, 16'h0000, 16'h5A9F},  // R9 level 1 = 23199
    {16'h003E, 16'h0000, 16'h00B7},  // R9 level 15 = 183
    {16'h4020, 16'h1234, 16'h1234},  // R5 external
    {16'hC020, 16'h1234, 16'h0000},  // R4 muted external
    {16'h0000, 16'h0000, 16'h0000},  // R6 tone off
    {16'h401E, 16'hFFFB, 16'hFFFB}   // R5 external, tone off
  };

  function automatic logic [15:0] amp_of(input int n);
    int a;
    a = 32767;
    for (int i = 0; i < n; i++) a = (a * 708) / 1000;
    return a[15:0];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] a0;
    a0 = amp_of(0);
    repeat (3) @(negedge clk);
    check("R1 cfg", cfg_rdata, 16'h8000);
    check("R1 valid", {15'b0, smp_valid}, 16'h0000);
    check("R1 data", smp_data, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 8; i++) begin
      wr(16'h0000); strobe();
      ext_sample = VEC[i][31:16];
      wr(VEC[i][47:32]);
      strobe();
      check("R4/R5/R6/R9 vector", smp_data, VEC[i][15:0]);
    end

    // R9 computed table values
    for (int l = 0; l < 16; l++) begin
      wr(16'h0000); strobe();
      wr(16'h0020 | 16'(l << 1)); strobe();
      check("R9 level", smp_data, amp_of(l));
    end

    // R2 reserved bits
    wr(16'hFFFF);
    check("R2 readback", cfg_rdata, 16'hDFFE);
    wr(16'h2001);
    check("R2 reserved only", cfg_rdata, 16'h0000);

    // R3 valid timing and hold
    wr(16'h4000); ext_sample = 16'h0ABC;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R3 valid after tick", {15'b0, smp_valid}, 16'h0001);
    ext_sample = 16'h0555;
    @(negedge clk);
    check("R3 valid low", {15'b0, smp_valid}, 16'h0000);
    check("R3 hold", smp_data, 16'h0ABC);

    // R7 F=3: 6 positive, 6 negative, 6 positive
    wr(16'h0000); strobe();
    wr(16'h0060);
    for (int k = 0; k < 18; k++) begin
      strobe();
      check("R7 period", smp_data, ((k / 6) % 2 == 0) ? a0 : (~a0 + 16'd1));
    end

    // R8 F=2 then change to F=1 after one sample
    wr(16'h0000); strobe();
    wr(16'h0040); strobe();
    check("R8 first", smp_data, a0);
    wr(16'h0020);
    for (int k = 0; k < 7; k++) begin
      strobe();
      check("R8 deferred reload", smp_data, (k < 3 || k >= 5) ? a0 : (~a0 + 16'd1));
    end

    // R6 disable in negative half, re-enable starts positive
    wr(16'h0000); strobe();
    wr(16'h0020); strobe(); strobe(); strobe();
    check("R6 in negative half", smp_data, ~a0 + 16'd1);
    wr(16'h0000); strobe();
    check("R6 silent", smp_data, 16'h0000);
    wr(16'h0020); strobe();
    check("R6 restart positive", smp_data, a0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule